// File: doc/BRIEF.md
# Binary Code Modulation LED Shift-Register Driver

The block dims 32 LED outputs hanging off a chain of serial-in, parallel-out shift registers with latched outputs. Each channel has a 12-bit level. Binary code modulation splits one frame into 12 slots, one per bit weight. In slot `i` the block sends one bit-plane word to the chain. Bit `j` of that word is bit `i` of channel `j`'s level. The word is latched to the LED outputs, and then the block waits for a time that doubles from one weight to the next. Converting the 32 levels into 12 bit-plane words happens inside the block, so the user only ever writes levels.

Each slot begins with a short clear pulse on the register chain. The serial transfer follows and ends well inside a fixed transfer allowance. At the end of that allowance a storage strobe latches the word, and the slot then runs for its binary-weighted display time. The length of each slot is set only at the boundary where the slot begins. The frame length and the on-time of every weight therefore never drift. Level writes go into a staging copy. They are shown only from the first slot of the frame after a commit, so one frame never shows a mix of two images.

Top module: `bcm_led_driver`

## Requirements
- R1: Slots run for plane 0, 1, …, PLANES-1 and then return to plane 0. The first slot after reset is plane 0. The slot for plane `i` lasts XFER_TICKS + DEAD_TICKS + (BASE_TICKS << i) clock cycles, which is 132 + 4·2^i with the default values. The time from one strobe rising edge to the next therefore equals the length of the earlier slot.
- R2: The word latched in the slot for plane `i` has bit `j` equal to bit `i` of the level currently shown for channel `j`.
- R3: The word is sent as NUM_CH/WORD_W words of WORD_W bits. Word bits 15..0 go first, then bits 31..16, and each half is sent most significant bit first. `sr_sck` idles low. `sr_sdo` changes only while `sr_sck` is low and holds steady while it is high. There is one rising edge of `sr_sck` per bit, 32 per slot.
- R4: `sr_clear_n` is active low. It is low for exactly the first DEAD_TICKS cycles of every slot. No `sr_sck` activity occurs while the clear is asserted or the strobe is high, or between a strobe and the next clear.
- R5: `sr_strobe` goes high at cycle XFER_TICKS of a slot and stays high for DEAD_TICKS cycles. Its rising edge comes XFER_TICKS − DEAD_TICKS cycles after the clear is released. Strobe high and clear low never overlap.
- R6: The plane index and the slot length change only on the slot boundary, where the length for the new plane is loaded.
- R7: A write (`wr_en` with `wr_ch`, `wr_level`) changes only the staging copy. Without a commit it has no effect on any latched word.
- R8: A `commit` pulse makes the whole staging copy visible from the next plane-0 slot. The planes left in the frame in progress still show the old image. Channels not rewritten since the last commit keep their staged values.
- R9: During reset `sr_clear_n`, `sr_strobe`, `sr_sck` and `sr_sdo` are all low, and the shown image is all zero. After release the clear stays low until cycle DEAD_TICKS of the first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timer tick |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the staging copy |
| wr_ch | input | $clog2(NUM_CH) | Channel written |
| wr_level | input | PLANES | Level written |
| commit | input | 1 | Show the staging copy from the next plane-0 slot |
| sr_sck | output | 1 | Shift clock, idles low, data taken on the rising edge |
| sr_sdo | output | 1 | Serial data to the chain |
| sr_clear_n | output | 1 | Shift-register clear, active low |
| sr_strobe | output | 1 | Storage latch strobe, active high |

## Verification
The bench follows the pins and rebuilds every latched word from the serial bits. It compares each word against a level model and measures every clear width, strobe width, strobe offset and slot length in cycles. A weight off by one bit position, or a slot length loaded from the wrong plane index, shows up as a spacing error between strobes. If the two 16-bit halves are swapped or sent LSB first, the rebuilt word has its bits in the wrong places. The bench commits a new image in the middle of a frame. A design that swaps images at once, instead of at the next plane 0, shows new data in the remaining planes of that frame. Writes left uncommitted for a full frame catch a design that lets staged data leak through. A partial rewrite before a commit catches a design that clears staged channels on commit.

// File: rtl/bcm_pkg.sv
// Shared helpers for the binary code modulation driver.
// Assumes slot lengths fit in 32 bits for every legal parameter set.
package bcm_pkg;

    // Length in ticks of the slot that displays plane idx.
    function automatic int bcm_slot_ticks(input int xfer, input int dead,
                                          input int base, input int idx);
        return xfer + dead + (base << idx);
    endfunction

endpackage

// File: rtl/bcm_slot_timer.sv
// Slot sequencer: counts ticks within a slot, walks the plane index and
// produces the registered clear and strobe pins. The length of a slot is
// loaded only on the boundary at which the slot starts.
// Assumes XFER_TICKS >= 2*DEAD_TICKS and room for the serial transfer.
module bcm_slot_timer #(
    parameter int PLANES     = 12,
    parameter int BASE_TICKS = 4,
    parameter int DEAD_TICKS = 4,
    parameter int XFER_TICKS = 128,
    parameter int TICK_W     = 14,
    parameter int PL_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TICK_W-1:0] tick,
    output logic [PL_W-1:0]   plane,
    output logic              frame_edge,
    output logic              xfer_go,
    output logic              clear_n,
    output logic              strobe
);
    logic [TICK_W-1:0] cur_len, len_nxt, tick_nxt;
    logic [PL_W-1:0]   plane_nxt;
    logic              last;

    // Next-state decode for the tick counter, plane index and slot length.
    always_comb begin
        last      = (tick == cur_len - TICK_W'(1));
        tick_nxt  = last ? '0 : tick + TICK_W'(1);
        plane_nxt = plane;
        len_nxt   = cur_len;
        if (last) begin
            plane_nxt = (plane == PL_W'(PLANES - 1)) ? '0 : plane + PL_W'(1);
            len_nxt   = TICK_W'(bcm_pkg::bcm_slot_ticks(XFER_TICKS, DEAD_TICKS,
                                                        BASE_TICKS, int'(plane_nxt)));
        end
    end

    // Boundary into plane 0 and the cycle that launches the serial transfer.
    assign frame_edge = last && (plane_nxt == '0);
    assign xfer_go    = (tick == TICK_W'(DEAD_TICKS));

    // State registers; pins are decoded from the next tick so they align with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick    <= '0;
            plane   <= '0;
            cur_len <= TICK_W'(bcm_pkg::bcm_slot_ticks(XFER_TICKS, DEAD_TICKS,
                                                       BASE_TICKS, 0));
            clear_n <= 1'b0;
            strobe  <= 1'b0;
        end else begin
            tick    <= tick_nxt;
            plane   <= plane_nxt;
            cur_len <= len_nxt;
            clear_n <= (tick_nxt >= TICK_W'(DEAD_TICKS));
            strobe  <= (tick_nxt >= TICK_W'(XFER_TICKS)) &&
                       (tick_nxt <  TICK_W'(XFER_TICKS + DEAD_TICKS));
        end
    end
endmodule

// File: rtl/bcm_frame_store.sv
// Double-buffered level storage with bit-plane transposition.
// Writes land in a staging copy; a commit is held pending and the staging
// copy becomes the shown copy on the next plane-0 boundary.
// Assumes plane_sel < LVL_W.
module bcm_frame_store #(
    parameter int NUM_CH = 32,
    parameter int LVL_W  = 12,
    parameter int CH_AW  = 5,
    parameter int PL_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_AW-1:0]  wr_ch,
    input  logic [LVL_W-1:0]  wr_level,
    input  logic              commit,
    input  logic              swap,
    input  logic [PL_W-1:0]   plane_sel,
    output logic [NUM_CH-1:0] plane_word
);
    logic [LVL_W-1:0] stage_q [NUM_CH];
    logic [LVL_W-1:0] show_q  [NUM_CH];
    logic             pending_q;

    // Staging writes, commit bookkeeping and the frame-boundary copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_CH; j++) begin
                stage_q[j] <= '0;
                show_q[j]  <= '0;
            end
            pending_q <= 1'b0;
        end else begin
            if (wr_en) stage_q[wr_ch] <= wr_level;
            if (swap && pending_q) begin
                for (int j = 0; j < NUM_CH; j++) show_q[j] <= stage_q[j];
                pending_q <= commit;
            end else if (commit) begin
                pending_q <= 1'b1;
            end
        end
    end

    // Transposition: one bit of every shown level forms the plane word.
    for (genvar j = 0; j < NUM_CH; j++) begin : g_plane
        assign plane_word[j] = show_q[j][plane_sel];
    end
endmodule

// File: rtl/bcm_serializer.sv
// Mode-0 serial shifter: on go it captures a word, reorders it so the
// lowest WORD_W-bit word leaves first, and sends every word MSB first,
// two clock cycles per bit (low phase, then high phase).
// Assumes NUM_CH is a multiple of WORD_W and go is not repeated mid-transfer.
module bcm_serializer #(
    parameter int NUM_CH = 32,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [NUM_CH-1:0] word,
    output logic              sck,
    output logic              sdo
);
    localparam int NWORDS = NUM_CH / WORD_W;
    localparam int PH_W   = $clog2(2 * NUM_CH);

    logic [NUM_CH-1:0] stream, sreg;
    logic [PH_W-1:0]   ph;
    logic              busy;

    // Word order on the wire: word 0 occupies the top of the stream.
    for (genvar w = 0; w < NWORDS; w++) begin : g_order
        assign stream[(NWORDS-1-w)*WORD_W +: WORD_W] = word[w*WORD_W +: WORD_W];
    end

    // Bit engine: raise sck on even phases, advance data on odd phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            ph   <= '0;
            busy <= 1'b0;
            sck  <= 1'b0;
            sdo  <= 1'b0;
        end else if (go) begin
            sreg <= stream;
            ph   <= '0;
            busy <= 1'b1;
            sck  <= 1'b0;
            sdo  <= stream[NUM_CH-1];
        end else if (busy) begin
            ph <= ph + PH_W'(1);
            if (!ph[0]) begin
                sck <= 1'b1;
            end else begin
                sck  <= 1'b0;
                sreg <= sreg << 1;
                sdo  <= sreg[NUM_CH-2];
                if (ph == PH_W'(2 * NUM_CH - 1)) begin
                    busy <= 1'b0;
                    sdo  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/bcm_led_driver.sv
// Top of the binary code modulation LED driver. Ties the slot sequencer,
// the double-buffered level store and the serial shifter together.
// One clock cycle is one timer tick. Assumes the serial transfer
// (2*NUM_CH cycles) ends before XFER_TICKS.
module bcm_led_driver #(
    parameter int NUM_CH     = 32,
    parameter int WORD_W     = 16,
    parameter int PLANES     = 12,
    parameter int BASE_TICKS = 4,
    parameter int DEAD_TICKS = 4,
    parameter int XFER_TICKS = 128,
    localparam int CH_AW     = $clog2(NUM_CH),
    localparam int PL_W      = $clog2(PLANES),
    localparam int LEN_MAX   = XFER_TICKS + DEAD_TICKS + (BASE_TICKS << (PLANES - 1)),
    localparam int TICK_W    = $clog2(LEN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_AW-1:0]  wr_ch,
    input  logic [PLANES-1:0] wr_level,
    input  logic              commit,
    output logic              sr_sck,
    output logic              sr_sdo,
    output logic              sr_clear_n,
    output logic              sr_strobe
);
    logic [TICK_W-1:0] tick;
    logic [PL_W-1:0]   plane_idx;
    logic              frame_edge, xfer_go;
    logic [NUM_CH-1:0] plane_word;

    // Slot timing and the clear/strobe pins.
    bcm_slot_timer #(
        .PLANES(PLANES), .BASE_TICKS(BASE_TICKS), .DEAD_TICKS(DEAD_TICKS),
        .XFER_TICKS(XFER_TICKS), .TICK_W(TICK_W), .PL_W(PL_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .plane(plane_idx),
        .frame_edge(frame_edge), .xfer_go(xfer_go),
        .clear_n(sr_clear_n), .strobe(sr_strobe)
    );

    // Level storage and transposition into the current plane word.
    bcm_frame_store #(
        .NUM_CH(NUM_CH), .LVL_W(PLANES), .CH_AW(CH_AW), .PL_W(PL_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_level(wr_level), .commit(commit), .swap(frame_edge),
        .plane_sel(plane_idx), .plane_word(plane_word)
    );

    // Serial transfer of the plane word.
    bcm_serializer #(
        .NUM_CH(NUM_CH), .WORD_W(WORD_W)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .go(xfer_go), .word(plane_word),
        .sck(sr_sck), .sdo(sr_sdo)
    );
endmodule

// File: rtl/bcm_led_driver_chk.sv
// Property checker for bcm_led_driver, attached with bind below.
module bcm_led_driver_chk #(
    parameter int PLANES = 12,
    parameter int TICK_W = 14,
    parameter int PL_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              sdo,
    input logic              clear_n,
    input logic              strobe,
    input logic [TICK_W-1:0] tick,
    input logic [PL_W-1:0]   plane
);
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && !clear_n));

    a_r4_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe || !clear_n) |-> !sck);

    a_r3_sdo_held: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(sdo));

    a_r6_plane_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(plane) |-> (tick == '0));

    a_r1_plane_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(plane) |-> ((plane == '0) || (plane == $past(plane) + PL_W'(1))));

    a_r1_plane_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(plane) < PLANES);
endmodule

bind bcm_led_driver bcm_led_driver_chk #(
    .PLANES(PLANES), .TICK_W(TICK_W), .PL_W(PL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sck(sr_sck), .sdo(sr_sdo),
    .clear_n(sr_clear_n), .strobe(sr_strobe), .tick(tick), .plane(plane_idx)
);

// File: tb/sim_bcm_led_driver.sv
// Pin-level bench: rebuilds each latched word from the serial pins and
// measures every pulse and slot against a level model.
module sim_bcm_led_driver;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 32;
    localparam int WW   = 16;
    localparam int PL   = 6;
    localparam int BASE = 4;
    localparam int DEAD = 4;
    localparam int XFER = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_ch = '0;
    logic [PL-1:0] wr_level = '0;
    logic          commit = 1'b0;
    logic          sr_sck, sr_sdo, sr_clear_n, sr_strobe;

    bcm_led_driver #(
        .NUM_CH(NCH), .WORD_W(WW), .PLANES(PL), .BASE_TICKS(BASE),
        .DEAD_TICKS(DEAD), .XFER_TICKS(XFER)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_level(wr_level), .commit(commit), .sr_sck(sr_sck),
        .sr_sdo(sr_sdo), .sr_clear_n(sr_clear_n), .sr_strobe(sr_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int slot_len(input int p);
        return XFER + DEAD + (BASE << p);
    endfunction

    // Level model
    logic [PL-1:0] stage_m [NCH];
    logic [PL-1:0] show_m  [NCH];
    bit            pend_m = 1'b0;
    string         word_tag = "R9 zero image after reset";

    // Pin monitor state
    int  cyc = 0, nbits = 0, n_stb = 0;
    int  t_clr_rise = 0, t_clr_fall = 0, t_stb_rise = 0;
    bit  fall_seen = 1'b0, first_rise = 1'b1;
    int  plane_m = 0, last_plane = 0;
    logic prev_sck = 1'b0, prev_clr = 1'b0, prev_stb = 1'b0;
    logic [NCH-1:0] cap = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (sr_sck && !prev_sck) begin
                if (nbits < NCH)
                    cap[(nbits / WW) * WW + (WW - 1 - nbits % WW)] = sr_sdo;
                nbits++;
            end
            if (!sr_clear_n && prev_clr) begin
                check(nbits == 0, "R4 no sck between strobe and clear", nbits, 0);
                check(cyc - t_stb_rise == slot_len(last_plane) - XFER,
                      "R1 strobe to next slot start", cyc - t_stb_rise,
                      slot_len(last_plane) - XFER);
                t_clr_fall = cyc;
                fall_seen = 1'b1;
            end
            if (sr_clear_n && !prev_clr) begin
                if (first_rise)
                    check(cyc == DEAD, "R9 clear held after reset", cyc, DEAD);
                else
                    check(cyc - t_clr_fall == DEAD, "R4 clear width",
                          cyc - t_clr_fall, DEAD);
                check(nbits == 0, "R4 serial starts after clear", nbits, 0);
                first_rise = 1'b0;
                t_clr_rise = cyc;
            end
            if (sr_strobe && !prev_stb) begin
                logic [NCH-1:0] exp_w;
                check(cyc - t_clr_rise == XFER - DEAD, "R5 strobe offset",
                      cyc - t_clr_rise, XFER - DEAD);
                check(nbits == NCH, "R3 bits per slot", nbits, NCH);
                if (plane_m == 0 && pend_m) begin
                    for (int j = 0; j < NCH; j++) show_m[j] = stage_m[j];
                    pend_m = 1'b0;
                end
                for (int j = 0; j < NCH; j++) exp_w[j] = show_m[j][plane_m];
                check(cap == exp_w, word_tag, cap, exp_w);
                if (n_stb > 0)
                    check(cyc - t_stb_rise == slot_len(last_plane),
                          "R1 R6 slot length", cyc - t_stb_rise, slot_len(last_plane));
                else
                    check(cyc == XFER, "R1 first slot is plane 0", cyc, XFER);
                last_plane = plane_m;
                plane_m = (plane_m + 1) % PL;
                t_stb_rise = cyc;
                nbits = 0;
                cap = '0;
                n_stb++;
            end
            if (!sr_strobe && prev_stb)
                check(cyc - t_stb_rise == DEAD, "R5 strobe width",
                      cyc - t_stb_rise, DEAD);
        end
        prev_sck = sr_sck;
        prev_clr = sr_clear_n;
        prev_stb = sr_strobe;
    end

    task automatic wr(input int ch, input int lvl);
        @(negedge clk);
        wr_en    <= 1'b1;
        wr_ch    <= 5'(ch);
        wr_level <= PL'(lvl);
        stage_m[ch] = PL'(lvl);
        @(negedge clk);
        wr_en <= 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit <= 1'b1;
        pend_m = 1'b1;
        @(negedge clk);
        commit <= 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        for (int j = 0; j < NCH; j++) begin
            stage_m[j] = '0;
            show_m[j]  = '0;
        end
        // R9: pins during reset
        repeat (5) begin
            @(negedge clk);
            check(!sr_clear_n && !sr_strobe && !sr_sck && !sr_sdo,
                  "R9 reset pin state",
                  {sr_clear_n, sr_strobe, sr_sck, sr_sdo}, 0);
        end
        @(negedge clk);
        rst_n <= 1'b1;

        // Image A committed in mid-frame: rest of this frame stays old (R8)
        wait (n_stb == 2 * PL + 2);
        for (int j = 0; j < NCH; j++) wr(j, (j * 37 + 5) % (1 << PL));
        do_commit();
        word_tag = "R8 commit waits for plane 0";
        wait (n_stb == 3 * PL);
        word_tag = "R2 plane word image A";

        // Uncommitted writes must stay hidden for a full frame (R7)
        wait (n_stb == 4 * PL + 2);
        for (int j = 0; j < 8; j++) wr(j, ~((j * 37 + 5) % (1 << PL)));
        word_tag = "R7 staged write hidden";

        // Image B: all levels full scale
        wait (n_stb == 6 * PL + 2);
        for (int j = 0; j < NCH; j++) wr(j, (1 << PL) - 1);
        do_commit();
        word_tag = "R8 old image until plane 0";
        wait (n_stb == 7 * PL);
        word_tag = "R2 plane word full scale";

        // Image C: one weight per channel
        wait (n_stb == 8 * PL + 2);
        for (int j = 0; j < NCH; j++) wr(j, 1 << (j % PL));
        do_commit();
        wait (n_stb == 9 * PL);
        word_tag = "R2 plane word single weights";

        // Partial rewrite: other channels keep their staged values (R8)
        wait (n_stb == 10 * PL + 2);
        wr(3, 0);
        wr(30, (1 << PL) - 2);
        do_commit();
        wait (n_stb == 11 * PL);
        word_tag = "R8 partial rewrite keeps staged channels";
        wait (n_stb == 12 * PL + 1);
        @(negedge clk);
        finish_run();
    end
endmodule